// File: doc/BRIEF.md
# Triggered Noise and Triangle DAC Data Generator

This block forms the 12-bit code for one DAC channel. A base value is taken from the input port. Optionally, pseudo-random noise or a triangle wave is added to it. The result is clipped at full scale. A new code is produced either every clock (free-running mode) or on a trigger pulse picked by a 3-bit source code. The sources are five external pulse lines and a software strobe. One 4-bit width field sets both the noise mask and the triangle peak. The channel enable and the output-buffer control bit pass straight through to the analog side.

The behaviour is held in a three-state run controller:

- `ST_OFF`: the channel is disabled.
- `ST_DIRECT`: the trigger is disabled, so the base value is copied out.
- `ST_ARMED`: the output waits for the selected trigger.

The next state is decided each clock from the enable inputs. Transitions are ST_OFF→ST_DIRECT/ST_ARMED when the channel enable rises (trigger enable picks which), ST_DIRECT↔ST_ARMED when the trigger enable changes, and any state→ST_OFF when the channel enable falls. Each transition lands one clock after the input changes.

The triangle generator has its own two-state direction machine, `TRI_RISE` and `TRI_FALL`. It goes TRI_RISE→TRI_FALL on a step taken at or above the peak. It goes TRI_FALL→TRI_RISE on a step taken at zero.

Top module: `dac_wave_pacer`

## Requirements
- R1: After reset, `dac_code` is 0 and `dac_update` is 0. The noise register holds 0xAAA. The triangle counter is 0 and rising.
- R2: `wave_mode` selects what is added to the base: 00 adds nothing, 01 adds masked noise, and 10 or 11 add the triangle. The width field k gives n = k+1 bits, clamped to 12 for k of 11 or more. A trigger in mode 00 outputs the base and advances no generator.
- R3: In noise mode, each accepted trigger shifts the 12-bit noise register one place toward the MSB. The new bit 0 is the XOR of old bits 11, 5, 3 and 0. The value added is the new register value ANDed with 2^n−1.
- R4: In triangle mode, each accepted trigger steps the counter. While rising, it goes up by 1, or down by 1 (turning to falling) once it is at or above 2^n−1. While falling, it goes down by 1, or to 1 (turning to rising) once it is at 0. The new count is added to the base.
- R5: The sum of base and wave is clipped at 4095 and never wraps.
- R6: With trigger enable 1, `trig_sel` picks the trigger source: 000→`ext_trig[0]`, 001→`ext_trig[1]`, 010→`ext_trig[2]`, 101→`ext_trig[3]`, 110→`ext_trig[4]`, 111→`sw_trig`. A pulse on the selected line loads the new code on the next edge, with `dac_update` high for that one cycle.
- R7: Select codes 011 and 100 never cause an update and never advance a generator. Pulses on unselected lines are ignored in the same way.
- R8: From the second clock after trigger enable goes 0 with the channel enabled, `dac_code` equals the base value of the previous cycle. `dac_update` is high for one cycle when that loaded value differs from the old code. Triggers are ignored and the generators stay frozen.
- R9: From the second clock after the channel enable goes 0, `dac_update` stays 0 and `dac_code` holds its value. Triggers and base changes are ignored, and the generators stay frozen.
- R10: `chan_en_out` and `buf_off_out` follow `chan_en` and `buf_off` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable |
| buf_off | input | 1 | Output-buffer off control |
| base_data | input | 12 | Base DAC value |
| wave_mode | input | 2 | 00 none, 01 noise, 1x triangle |
| wave_width | input | 4 | Wave bit width minus one |
| trig_en | input | 1 | 1 = paced by trigger, 0 = free-running copy |
| trig_sel | input | 3 | Trigger source code |
| ext_trig | input | 5 | External trigger pulse lines |
| sw_trig | input | 1 | Software trigger strobe, one cycle |
| dac_code | output | 12 | DAC code |
| dac_update | output | 1 | One-cycle pulse when a code is loaded |
| chan_en_out | output | 1 | Channel enable pass-through |
| buf_off_out | output | 1 | Buffer control pass-through |

## Verification
The assertions check the following on every cycle:

- The disabled state keeps the code still and the update strobe low.
- The free-running state copies the base.
- Reserved select codes and unselected lines never raise the strobe.
- A triggered load never lands below the base.
- The noise register never reaches zero.
- The triangle moves by exactly one per step.

Only the bench scenarios can show the full noise sequence and its masking across all sixteen width codes. The same holds for the exact turning points of the triangle, the mapping of each select code to its line, and the fact that disabled and free-running spells leave both generators frozen.

// File: rtl/dwg_pkg.sv
package dwg_pkg;

    localparam int EXT_LINES = 5;

    localparam logic [2:0] TSEL_EXT0 = 3'b000;
    localparam logic [2:0] TSEL_EXT1 = 3'b001;
    localparam logic [2:0] TSEL_EXT2 = 3'b010;
    localparam logic [2:0] TSEL_EXT3 = 3'b101;
    localparam logic [2:0] TSEL_EXT4 = 3'b110;
    localparam logic [2:0] TSEL_SOFT = 3'b111;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_DIRECT = 2'd1,
        ST_ARMED  = 2'd2
    } run_state_e;

    typedef enum logic {
        TRI_RISE = 1'b0,
        TRI_FALL = 1'b1
    } tri_dir_e;

endpackage

// File: rtl/dwg_trig_mux.sv
module dwg_trig_mux
    import dwg_pkg::*;
(
    input  logic [2:0]           sel,
    input  logic [EXT_LINES-1:0] ext,
    input  logic                 sw,
    output logic                 hit
);

    always_comb begin
        unique case (sel)
            TSEL_EXT0: hit = ext[0];
            TSEL_EXT1: hit = ext[1];
            TSEL_EXT2: hit = ext[2];
            TSEL_EXT3: hit = ext[3];
            TSEL_EXT4: hit = ext[4];
            TSEL_SOFT: hit = sw;
            default:   hit = 1'b0;   // reserved codes never fire
        endcase
    end

endmodule

// File: rtl/dwg_lfsr.sv
module dwg_lfsr #(
    parameter int           W    = 12,
    parameter logic [W-1:0] SEED = 12'hAAA,
    parameter logic [W-1:0] TAPS = 12'h829
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] nxt
);

    logic [W-1:0] q;

    assign nxt = {q[W-2:0], ^(q & TAPS)};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (step) begin
            q <= nxt;
        end
    end

    // R3: a nonzero seed under an invertible shift can never reach zero
    p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);

endmodule

// File: rtl/dwg_triangle.sv
module dwg_triangle
    import dwg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] amp,
    output logic [W-1:0] cnt_nxt
);

    logic [W-1:0] cnt_q;
    tri_dir_e     dir_q, dir_d;

    always_comb begin
        cnt_nxt = cnt_q;
        dir_d   = dir_q;
        unique case (dir_q)
            TRI_RISE: begin
                if (cnt_q >= amp) begin
                    cnt_nxt = cnt_q - 1'b1;
                    dir_d   = TRI_FALL;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            TRI_FALL: begin
                if (cnt_q == '0) begin
                    cnt_nxt = W'(1);
                    dir_d   = TRI_RISE;
                end else begin
                    cnt_nxt = cnt_q - 1'b1;
                end
            end
            default: begin
                cnt_nxt = '0;
                dir_d   = TRI_RISE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= TRI_RISE;
        end else if (step) begin
            cnt_q <= cnt_nxt;
            dir_q <= dir_d;
        end
    end

    // R4: every step moves the count by exactly one
    p_tri_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((cnt_q - $past(cnt_q)) == W'(1)) || (($past(cnt_q) - cnt_q) == W'(1)));

endmodule

// File: rtl/dac_wave_pacer.sv
module dac_wave_pacer
    import dwg_pkg::*;
#(
    parameter int              DATA_W    = 12,
    parameter int              WID_W     = 4,
    parameter logic [DATA_W-1:0] LFSR_SEED = 12'hAAA,
    parameter logic [DATA_W-1:0] LFSR_TAPS = 12'h829
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chan_en,
    input  logic                 buf_off,
    input  logic [DATA_W-1:0]    base_data,
    input  logic [1:0]           wave_mode,
    input  logic [WID_W-1:0]     wave_width,
    input  logic                 trig_en,
    input  logic [2:0]           trig_sel,
    input  logic [EXT_LINES-1:0] ext_trig,
    input  logic                 sw_trig,
    output logic [DATA_W-1:0]    dac_code,
    output logic                 dac_update,
    output logic                 chan_en_out,
    output logic                 buf_off_out
);

    localparam int SUM_W = DATA_W + 1;

    run_state_e        state_q, state_d;
    logic              hit, fire;
    logic              lfsr_step, tri_step;
    logic [DATA_W-1:0] wmask, lfsr_nxt, tri_nxt, wave_add, clipped;
    logic [SUM_W-1:0]  sum;

    assign chan_en_out = chan_en;
    assign buf_off_out = buf_off;

    dwg_trig_mux u_mux (
        .sel (trig_sel),
        .ext (ext_trig),
        .sw  (sw_trig),
        .hit (hit)
    );

    // bits [k:0] set, which saturates at the full word for large k
    always_comb begin
        wmask = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i <= int'(wave_width)) wmask[i] = 1'b1;
        end
    end

    assign fire      = (state_q == ST_ARMED) && hit;
    assign lfsr_step = fire && (wave_mode == 2'b01);
    assign tri_step  = fire && wave_mode[1];

    dwg_lfsr #(
        .W    (DATA_W),
        .SEED (LFSR_SEED),
        .TAPS (LFSR_TAPS)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (lfsr_step),
        .nxt   (lfsr_nxt)
    );

    dwg_triangle #(
        .W (DATA_W)
    ) u_tri (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (tri_step),
        .amp     (wmask),
        .cnt_nxt (tri_nxt)
    );

    always_comb begin
        unique case (wave_mode)
            2'b00:   wave_add = '0;
            2'b01:   wave_add = lfsr_nxt & wmask;
            default: wave_add = tri_nxt;
        endcase
    end

    assign sum     = {1'b0, base_data} + {1'b0, wave_add};
    assign clipped = sum[DATA_W] ? '1 : sum[DATA_W-1:0];

    // next-state decision
    always_comb begin
        if (!chan_en) begin
            state_d = ST_OFF;
        end else if (trig_en) begin
            state_d = ST_ARMED;
        end else begin
            state_d = ST_DIRECT;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code   <= '0;
            dac_update <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    dac_update <= 1'b0;
                end
                ST_DIRECT: begin
                    dac_code   <= base_data;
                    dac_update <= (base_data != dac_code);
                end
                ST_ARMED: begin
                    dac_update <= fire;
                    if (fire) dac_code <= clipped;
                end
                default: begin
                    dac_update <= 1'b0;
                end
            endcase
        end
    end

    // R9: a disabled channel is silent and holds its code
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (!dac_update && $stable(dac_code)));

    // R8: free-running state copies the base one clock later
    p_direct_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIRECT) |=> (dac_code == $past(base_data)));

    // R7: reserved select codes never update
    p_reserved_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ARMED) && ((trig_sel == 3'b011) || (trig_sel == 3'b100))) |=> !dac_update);

    // R6: armed channel updates only on a selected pulse
    p_update_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ARMED) && !hit) |=> !dac_update);

    // R5: a triggered load never wraps below the base
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (dac_update && (dac_code >= $past(base_data))));

endmodule

// File: tb/sim_dac_wave_pacer.sv
module sim_dac_wave_pacer;
    import dwg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chan_en, buf_off, trig_en, sw_trig;
    logic [11:0] base_data;
    logic [1:0]  wave_mode;
    logic [3:0]  wave_width;
    logic [2:0]  trig_sel;
    logic [4:0]  ext_trig;
    logic [11:0] dac_code;
    logic        dac_update, chan_en_out, buf_off_out;

    always #10 clk = ~clk;   // 50 MHz

    dac_wave_pacer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (chan_en),
        .buf_off     (buf_off),
        .base_data   (base_data),
        .wave_mode   (wave_mode),
        .wave_width  (wave_width),
        .trig_en     (trig_en),
        .trig_sel    (trig_sel),
        .ext_trig    (ext_trig),
        .sw_trig     (sw_trig),
        .dac_code    (dac_code),
        .dac_update  (dac_update),
        .chan_en_out (chan_en_out),
        .buf_off_out (buf_off_out)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [11:0] last_code;
    logic [11:0] m_lfsr;
    logic [11:0] m_cnt;
    bit          m_fall;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] m_mask(input logic [3:0] k);
        int n;
        n = (k >= 4'd11) ? 12 : int'(k) + 1;
        return 12'((1 << n) - 1);
    endfunction

    // advance the reference generators per R2, R3, R4
    task automatic model_step(output logic [11:0] add);
        logic [11:0] amp;
        amp = m_mask(wave_width);
        add = '0;
        if (wave_mode == 2'b01) begin
            m_lfsr = {m_lfsr[10:0], m_lfsr[11] ^ m_lfsr[5] ^ m_lfsr[3] ^ m_lfsr[0]};
            add = m_lfsr & amp;
        end else if (wave_mode[1]) begin
            if (!m_fall) begin
                if (m_cnt >= amp) begin m_cnt = m_cnt - 1; m_fall = 1; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin m_cnt = 1; m_fall = 0; end
                else m_cnt = m_cnt - 1;
            end
            add = m_cnt;
        end
    endtask

    // pulse one line (0..4 external, 5 software) and check the result
    task automatic fire(input int line, input bit hit, input string req);
        logic [11:0] add;
        logic [11:0] exp;
        int          s;
        if (hit) begin
            model_step(add);
            s   = int'(base_data) + int'(add);
            exp = (s > 4095) ? 12'hFFF : 12'(s);
        end else begin
            exp = last_code;
        end
        @(negedge clk);
        if (line < 5) ext_trig[line] = 1'b1;
        else sw_trig = 1'b1;
        @(negedge clk);
        ext_trig = '0;
        sw_trig  = 1'b0;
        check_eq(req, int'(dac_update), int'(hit));
        check_eq(req, int'(dac_code), int'(exp));
        last_code = exp;
    endtask

    task automatic direct_write(input logic [11:0] v);
        @(negedge clk);
        base_data = v;
        @(negedge clk);
        check_eq("R8", int'(dac_code), int'(v));
        check_eq("R8", int'(dac_update), int'(v != last_code));
        last_code = v;
    endtask

    function automatic int src_of(input logic [2:0] s);
        case (s)
            3'b000: return 0;
            3'b001: return 1;
            3'b010: return 2;
            3'b101: return 3;
            3'b110: return 4;
            3'b111: return 5;
            default: return -1;
        endcase
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; chan_en = 1'b0; buf_off = 1'b0; trig_en = 1'b0; sw_trig = 1'b0;
        base_data = '0; wave_mode = 2'b00; wave_width = '0; trig_sel = '0; ext_trig = '0;
        m_lfsr = 12'hAAA; m_cnt = '0; m_fall = 0; last_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", int'(dac_code), 0);
        check_eq("R1", int'(dac_update), 0);

        // R10 pass-through
        buf_off = 1'b1; #1;
        check_eq("R10", int'(buf_off_out), 1);
        check_eq("R10", int'(chan_en_out), 0);
        buf_off = 1'b0; chan_en = 1'b1; #1;
        check_eq("R10", int'(buf_off_out), 0);
        check_eq("R10", int'(chan_en_out), 1);

        // R8 free-running copy
        base_data = 12'h055;
        repeat (2) @(negedge clk);
        check_eq("R8", int'(dac_code), 12'h055);
        last_code = 12'h055;
        @(negedge clk);
        check_eq("R8", int'(dac_update), 0);
        direct_write(12'h123);
        direct_write(12'hFFF);
        direct_write(12'hFFF);
        direct_write(12'h000);
        direct_write(12'h800);
        direct_write(12'h7FF);
        trig_sel = 3'b111; wave_mode = 2'b01;
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
        check_eq("R8", int'(dac_update), 0);
        check_eq("R8", int'(dac_code), int'(last_code));

        // R6 / R7 select sweep in mode 00 (R2)
        wave_mode = 2'b00;
        @(negedge clk); trig_en = 1'b1;
        @(negedge clk);
        for (int sel = 0; sel < 8; sel++) begin
            trig_sel = 3'(sel);
            for (int line = 0; line < 6; line++) begin
                base_data = 12'(12'h300 + sel * 16 + line);
                if (src_of(3'(sel)) < 0) fire(line, 0, "R7");
                else fire(line, src_of(3'(sel)) == line, "R6");
            end
        end

        // R3 noise sweep over every width code, R2 clamp included
        wave_mode = 2'b01; trig_sel = 3'b111; base_data = 12'h200;
        for (int k = 0; k < 16; k++) begin
            wave_width = 4'(k);
            for (int j = 0; j < 4; j++) fire(5, 1, "R3");
        end

        // R7 reserved codes do not advance the noise
        for (int r = 3; r < 5; r++) begin
            trig_sel = 3'(r);
            for (int line = 0; line < 6; line++) fire(line, 0, "R7");
            trig_sel = 3'b111;
            fire(5, 1, "R7");
        end

        // R9 disabled channel
        @(negedge clk); chan_en = 1'b0;
        @(negedge clk);
        base_data = 12'h777;
        fire(5, 0, "R9");
        fire(0, 0, "R9");
        check_eq("R10", int'(chan_en_out), 0);
        @(negedge clk); chan_en = 1'b1;
        @(negedge clk);
        fire(5, 1, "R9");

        // R4 triangle
        wave_mode = 2'b10; wave_width = 4'd2; base_data = 12'h010;
        for (int j = 0; j < 20; j++) fire(5, 1, "R4");
        wave_mode = 2'b11; wave_width = 4'd0;
        for (int j = 0; j < 12; j++) fire(5, 1, "R4");
        wave_width = 4'd3;
        for (int j = 0; j < 34; j++) fire(5, 1, "R4");

        // R5 clipping
        base_data = 12'hFFC; wave_width = 4'd3;
        for (int j = 0; j < 20; j++) fire(5, 1, "R5");
        wave_mode = 2'b01; wave_width = 4'd15; base_data = 12'hFFF;
        for (int j = 0; j < 3; j++) fire(5, 1, "R5");
        base_data = 12'hE00;
        for (int j = 0; j < 8; j++) fire(5, 1, "R5");

        finished = 1;
        report;
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report;
            $finish;
        end
    end

endmodule